// File: doc/BRIEF.md
# Boot ROM Window Decoder Register

This block holds the control word for one ROM or flash window on a 32-bit processor bus and turns every bus address into a chip select, a write strobe and an offset into the device. The window starts at a 12-bit base that is compared with the top twelve address bits. A 3-bit size code makes the window 1 MB shifted left by the code, so the window is 1 MB to 128 MB. The base bits that fall inside the window are left out of the compare. Because of this, the window always starts at a whole multiple of its own size.

A vector alias bit makes the top megabyte of the address space (0xFFF00000 and up) also select the window, and that megabyte maps onto the window's first megabyte. A boot vector can therefore be fetched before software has programmed the base. A read-only width flag records at power-up whether the device is wide (64-bit) or narrow (16-bit). The flag is the inverse of a strap pin. Software reads and writes the control word through a plain register port. That port has no back-pressure: a write takes effect at the next clock edge, and read data comes back exactly one cycle after the request. Address decode is combinational from the bus inputs.

Top module: `boot_rom_window`

## Requirements
- R1: With size code 0 and the window enabled, a valid bus address selects the window exactly when address bits [31:20] equal the base.
- R2: Size code n makes the window 2^(20+n) bytes. The low n base bits are ignored in the compare, and rom_offset is the address modulo the window size.
- R3: Power-up reset and local reset both load base 0xFF4 and clear the size code, window enable and write enable.
- R4: With the alias bit and the window enabled, any address at or above 0xFFF00000 selects the window. The offset is then address bits [19:0], with the upper offset bits zero, and this mapping wins over the base match.
- R5: rom_cs is asserted only while bus_valid is 1 and the window enable is 1.
- R6: rom_we is asserted only for a selected bus write while the write enable is 1. A write with the write enable at 0 still drives rom_cs but gives no strobe.
- R7: The width flag is the inverse of strap_wide_n, captured during power-up reset. The alias bit takes strap_alias at power-up reset. Register writes never change the width flag, and local reset changes neither the width flag nor the alias bit.
- R8: The control word, in LSB-0 numbering, holds the base in [31:20], the width flag in [19], the size code in [18:16], the alias bit in [10], the window enable in [9] and the write enable in [8]. All other bits read as zero.
- R9: A read at REG_ADDR returns the word on cfg_rdata with cfg_rvalid high for one cycle, one cycle after cfg_rd. An access to any other address changes nothing and gives no cfg_rvalid.
- R10: A register write changes the decode from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, synchronous |
| lbrst_n | input | 1 | Local bus reset, active low, synchronous |
| strap_wide_n | input | 1 | Width strap; low means wide device |
| strap_alias | input | 1 | Power-up value of the vector alias bit |
| cfg_wr | input | 1 | Register write request |
| cfg_rd | input | 1 | Register read request |
| cfg_addr | input | 32 | Register access address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| bus_valid | input | 1 | Bus address valid |
| bus_write | input | 1 | Bus cycle is a write |
| bus_addr | input | 32 | Bus address |
| rom_cs | output | 1 | Window chip select |
| rom_we | output | 1 | Window write strobe |
| rom_offset | output | 27 | Byte offset inside the window |

## Verification
Every size code is tried with an unaligned base, and each probes the first byte, the last byte, one past the end, one before the start and the raw base. These probes show whether the mask drops too many or too few base bits. The top megabyte is probed with the alias bit off and on, and again with a large window that also covers it, which shows whether the alias offset wins. Writes are sent with the write enable cleared and set, and accesses go to a neighbouring register address, to show that strobes and side effects are gated. A pseudo-random run then pairs random control words with addresses near the base and near the top of memory.

// File: rtl/brw_pkg.sv
package brw_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int BASE_W  = 12;
  localparam int SZ_W    = 3;
  localparam int PAGE_LG = ADDR_W - BASE_W;                // 1 MB granule
  localparam int OFS_W   = PAGE_LG + (1 << SZ_W) - 1;      // largest window
  localparam logic [BASE_W-1:0] BASE_RST = 12'hFF4;

  // field positions, LSB-0 numbering
  localparam int F_BASE_LO = DATA_W - BASE_W;
  localparam int F_WIDE    = F_BASE_LO - 1;
  localparam int F_SZ_LO   = F_WIDE - SZ_W;
  localparam int F_ALIAS   = 10;
  localparam int F_EN      = 9;
  localparam int F_WE      = 8;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [SZ_W-1:0]   szcode;
    logic              wide;
    logic              vec_alias;
    logic              win_en;
    logic              wr_en;
  } win_cfg_t;

  function automatic logic [DATA_W-1:0] pack_word(input win_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DATA_W-1:F_BASE_LO]      = c.base;
    w[F_WIDE]                  = c.wide;
    w[F_SZ_LO+SZ_W-1:F_SZ_LO]  = c.szcode;
    w[F_ALIAS]                 = c.vec_alias;
    w[F_EN]                    = c.win_en;
    w[F_WE]                    = c.wr_en;
    return w;
  endfunction
endpackage

// File: rtl/brw_cfg_regs.sv
module brw_cfg_regs
  import brw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR = 32'hFEF80058
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              lbrst_n,
  input  logic              strap_wide_n,
  input  logic              strap_alias,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_rvalid,
  output win_cfg_t          cfg
);
  logic     hit;
  win_cfg_t cfg_q;

  assign hit = (cfg_addr == REG_ADDR);
  assign cfg = cfg_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      cfg_q.base      <= BASE_RST;
      cfg_q.szcode    <= '0;
      cfg_q.win_en    <= 1'b0;
      cfg_q.wr_en     <= 1'b0;
      cfg_q.wide      <= ~strap_wide_n;
      cfg_q.vec_alias <= strap_alias;
    end else if (!lbrst_n) begin
      cfg_q.base   <= BASE_RST;
      cfg_q.szcode <= '0;
      cfg_q.win_en <= 1'b0;
      cfg_q.wr_en  <= 1'b0;
    end else if (cfg_wr && hit) begin
      cfg_q.base      <= cfg_wdata[DATA_W-1:F_BASE_LO];
      cfg_q.szcode    <= cfg_wdata[F_SZ_LO+SZ_W-1:F_SZ_LO];
      cfg_q.vec_alias <= cfg_wdata[F_ALIAS];
      cfg_q.win_en    <= cfg_wdata[F_EN];
      cfg_q.wr_en     <= cfg_wdata[F_WE];
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !lbrst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_rd && hit;
      if (cfg_rd && hit) cfg_rdata <= pack_word(cfg_q);
    end
  end

  // R8
  ro_zero_chk: assert property (@(posedge clk) disable iff (!por_n || !lbrst_n)
    cfg_rvalid |-> (cfg_rdata[F_ALIAS+5:F_ALIAS+1] == '0 && cfg_rdata[F_WE-1:0] == '0));

  // R7
  wide_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_wr || !lbrst_n) |=> $stable(cfg_q.wide));

  // R9
  rd_latency_chk: assert property (@(posedge clk) disable iff (!por_n || !lbrst_n)
    cfg_rvalid |-> $past(cfg_rd));
endmodule

// File: rtl/brw_window_match.sv
module brw_window_match
  import brw_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              rom_cs,
  output logic              rom_we,
  output logic [OFS_W-1:0]  rom_offset
);
  logic [BASE_W-1:0] keep;
  logic [BASE_W-1:0] diff;
  logic [OFS_W-1:0]  span;
  logic              page_hit;
  logic              vec_hit;

  for (genvar g = 0; g < BASE_W; g++) begin : g_cmp
    assign keep[g] = (g >= int'(cfg.szcode));
    assign diff[g] = keep[g] & (bus_addr[PAGE_LG+g] ^ cfg.base[g]);
  end

  for (genvar g = 0; g < OFS_W; g++) begin : g_span
    assign span[g] = (g < PAGE_LG + int'(cfg.szcode));
  end

  assign page_hit = (diff == '0);
  assign vec_hit  = cfg.vec_alias && (bus_addr[ADDR_W-1:PAGE_LG] == '1);

  assign rom_cs     = bus_valid && cfg.win_en && (page_hit || vec_hit);
  assign rom_we     = rom_cs && bus_write && cfg.wr_en;
  assign rom_offset = vec_hit ? OFS_W'(bus_addr[PAGE_LG-1:0])
                              : (bus_addr[OFS_W-1:0] & span);
endmodule

// File: rtl/boot_rom_window.sv
module boot_rom_window
  import brw_pkg::*;
#(
  parameter logic [31:0] REG_ADDR = 32'hFEF80058
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        lbrst_n,
  input  logic        strap_wide_n,
  input  logic        strap_alias,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [31:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_rvalid,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [31:0] bus_addr,
  output logic        rom_cs,
  output logic        rom_we,
  output logic [26:0] rom_offset
);
  win_cfg_t cfg;

  brw_cfg_regs #(.REG_ADDR(REG_ADDR)) u_regs (
    .clk         (clk),
    .por_n       (por_n),
    .lbrst_n     (lbrst_n),
    .strap_wide_n(strap_wide_n),
    .strap_alias (strap_alias),
    .cfg_wr      (cfg_wr),
    .cfg_rd      (cfg_rd),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .cfg_rvalid  (cfg_rvalid),
    .cfg         (cfg)
  );

  brw_window_match u_match (
    .cfg       (cfg),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .rom_cs    (rom_cs),
    .rom_we    (rom_we),
    .rom_offset(rom_offset)
  );

  // R6
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!por_n || !lbrst_n)
    rom_we |-> (rom_cs && bus_write && cfg.wr_en));

  // R5
  cs_gate_chk: assert property (@(posedge clk) disable iff (!por_n || !lbrst_n)
    rom_cs |-> (bus_valid && cfg.win_en));

  // R4
  alias_map_chk: assert property (@(posedge clk) disable iff (!por_n || !lbrst_n)
    (bus_valid && cfg.vec_alias && cfg.win_en && bus_addr[31:20] == 12'hFFF)
      |-> (rom_cs && rom_offset[26:20] == '0 && rom_offset[19:0] == bus_addr[19:0]));
endmodule

// File: tb/boot_rom_window_bench.sv
module boot_rom_window_bench;
  localparam logic [31:0] RA = 32'hFEF80058;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        por_n = 1'b0, lbrst_n = 1'b1, strap_wide_n = 1'b0, strap_alias = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [31:0] cfg_addr = RA, cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        rom_cs, rom_we;
  logic [26:0] rom_offset;

  boot_rom_window u_boot_rom_window (.*);

  int n_chk = 0, n_fail = 0;
  bit chk_en = 1'b0;

  // behavioural reference state
  logic [11:0] m_base; logic [2:0] m_sz;
  logic m_wide, m_alias, m_en, m_we, m_rv;
  logic [31:0] m_rd;

  function automatic logic [31:0] m_word();
    return ({m_base, 20'h0}) | (32'(m_wide) << 19) | (32'(m_sz) << 16) |
           (32'(m_alias) << 10) | (32'(m_en) << 9) | (32'(m_we) << 8);
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      m_base = 12'hFF4; m_sz = 0; m_en = 0; m_we = 0; m_rv = 0; m_rd = 0;
      m_wide = !strap_wide_n; m_alias = strap_alias;
    end else if (!lbrst_n) begin
      m_base = 12'hFF4; m_sz = 0; m_en = 0; m_we = 0; m_rv = 0; m_rd = 0;
    end else begin
      m_rv = cfg_rd && cfg_addr == RA;
      if (m_rv) m_rd = m_word();
      if (cfg_wr && cfg_addr == RA) begin
        m_base = cfg_wdata[31:20]; m_sz = cfg_wdata[18:16];
        m_alias = cfg_wdata[10]; m_en = cfg_wdata[9]; m_we = cfg_wdata[8];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // compared every clock, half a period after the edge
  always @(negedge clk) if (chk_en) begin
    longint sz, start, ofs;
    bit nh, ah, cs, we;
    sz    = 64'd1 << (20 + m_sz);
    start = (longint'(m_base) << 20) & ~(sz - 1);
    nh    = (longint'(bus_addr) >= start) && (longint'(bus_addr) < start + sz);
    ah    = m_alias && (bus_addr >= 32'hFFF00000);
    cs    = bus_valid && m_en && (nh || ah);
    we    = cs && bus_write && m_we;
    ofs   = ah ? longint'(bus_addr) - 64'hFFF00000 : longint'(bus_addr) - start;
    chk(rom_cs == cs, "R1 R2 R4 R5 cs", rom_cs, cs);
    chk(rom_we == we, "R6 we", rom_we, we);
    if (cs) chk(longint'(rom_offset) == ofs, "R2 R4 offset", rom_offset, ofs);
    chk(cfg_rvalid == m_rv, "R9 rvalid", cfg_rvalid, m_rv);
    if (m_rv) chk(cfg_rdata == m_rd, "R8 rdata", cfg_rdata, m_rd);
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic wr_reg(input logic [31:0] a, input logic [31:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d; cyc(); cfg_wr = 0; cfg_addr = RA;
  endtask

  task automatic rd_chk(input logic [31:0] exp, input string req);
    cfg_rd = 1; cyc(); cfg_rd = 0;
    @(negedge clk);
    chk(cfg_rvalid && cfg_rdata == exp, req, cfg_rdata, exp);
    @(posedge clk); #2;
  endtask

  task automatic bus(input logic [31:0] a, input bit w);
    bus_valid = 1; bus_addr = a; bus_write = w; cyc(); bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_chk(input logic [31:0] a, input bit exp_cs, input string req);
    bus_valid = 1; bus_addr = a; bus_write = 0;
    @(negedge clk);
    chk(rom_cs == exp_cs, req, rom_cs, exp_cs);
    @(posedge clk); #2; bus_valid = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    repeat (3) cyc();
    por_n = 1; chk_en = 1; cyc();
    rd_chk(32'hFF480000, "R3 R7 reset word");
    bus_chk(32'hFF400000, 0, "R5 disabled window");
    wr_reg(RA, 32'hFF400200);
    bus_chk(32'hFF400000, 1, "R10 next-cycle decode");
    bus_chk(32'hFF4FFFFF, 1, "R1 last byte");
    bus_chk(32'hFF500000, 0, "R1 past end");
    bus_chk(32'hFF3FFFFF, 0, "R1 before start");
    bus(32'hFF400010, 1);
    wr_reg(RA, 32'hFF400300);
    bus(32'hFF400010, 1);
    bus_valid = 0; bus_addr = 32'hFF400000; cyc();
    for (int s = 0; s < 8; s++) begin
      longint sz, st;
      wr_reg(RA, 32'h12300300 | (32'(s) << 16));
      sz = 64'd1 << (20 + s);
      st = (64'h123 << 20) & ~(sz - 1);
      bus(32'(st), 0); bus(32'(st + sz - 1), 1); bus(32'(st + sz), 0);
      bus(32'(st - 1), 0); bus(32'h12345678, 0);
    end
    bus_chk(32'hFFF00000, 0, "R4 alias off");
    wr_reg(RA, 32'h12300700);
    bus_chk(32'hFFF00000, 1, "R4 alias on");
    bus(32'hFFFABCDE, 1);
    wr_reg(RA, 32'hFF830700);
    bus(32'hFFF12345, 0); bus(32'hFF812345, 0);
    wr_reg(RA, 32'hFFFFFFFF);
    rd_chk(32'hFFFF0700, "R7 R8 read-only bits");
    wr_reg(RA + 4, 32'h00000000);
    rd_chk(32'hFFFF0700, "R9 other address ignored");
    cfg_rd = 1; cfg_addr = RA + 4; cyc(); cfg_rd = 0; cfg_addr = RA; cyc();
    lbrst_n = 0; cyc(); lbrst_n = 1; cyc();
    rd_chk(32'hFF480400, "R3 R7 local reset");
    strap_wide_n = 1; strap_alias = 1; por_n = 0; cyc(); cyc(); por_n = 1; cyc();
    rd_chk(32'hFF400400, "R7 power-up strap");
    wr_reg(RA, 32'hFFFFFFFF);
    rd_chk(32'hFFF70700, "R7 width flag unwritable");
    lf = 32'hACE1_2468;
    for (int i = 0; i < 300; i++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      if (i % 6 == 0) wr_reg(RA, lf | 32'h00000200);
      else if (i % 2 == 0) bus({8'hFF, lf[23:0]}, lf[0]);
      else bus({m_base, lf[19:0]} ^ {lf[31:29], 29'h0}, lf[1]);
    end
    cyc();
    finish_run();
  end
endmodule